// File: doc/BRIEF.md
# CRC-6 Frame Builder for Copy-Protection Words

This block takes a copy-protection word exactly as software left it in the register file. It computes a 6-bit CRC over the payload part of the word and returns the assembled word, ready for the line serializer. It supports two frame formats. The short format is a 20-bit word with a 14-bit payload. The long format is a 134-bit packet with a 128-bit payload. In both formats the six CRC bits take the place of the six bits that sit just above the payload. When CRC generation is switched off, the word passes through untouched, so software can supply its own check field.

A caller presents the raw word, a format select and a CRC-enable bit, and pulses `start`. The block captures these inputs and feeds the payload bits, least significant first, into a 6-bit shift register, one bit per clock. The cycle after the last payload bit, it raises `done` for one cycle and presents the finished word on `word_out`. That word stays there until the next frame completes. A `start` pulse that arrives while a frame is in progress is ignored.

Top module: `crc6_frame_builder`

## Requirements
- R1: When `busy` is low, a high `start` at a rising clock edge captures `raw_word`, `fmt_sel` and `crc_en`, and `busy` is high after that edge. Later changes on these inputs do not affect the frame in progress.
- R2: The CRC register is preset to 6'b111111 at the start of each frame. For each payload bit `b`, taken from bit 0 upward, the feedback is `f = b ^ r[5]` and the update is `r <= {r[4:0],1'b0} ^ {4'b0000, f, f}`, which is the polynomial x^6 + x + 1.
- R3: With `fmt_sel` = 0 (short format) and CRC enabled, the CRC covers `raw_word[13:0]`. CRC register bit k lands at `word_out[14+k]`, and `word_out[133:20]` is zero.
- R4: With `fmt_sel` = 1 (long format) and CRC enabled, the CRC covers `raw_word[127:0]`, and CRC register bit k lands at `word_out[128+k]`.
- R5: With `crc_en` = 0, `word_out` equals the captured word in full for the long format. For the short format, `word_out[19:0]` equals the captured word's bits 19..0 and the bits above are zero.
- R6: `done` is high for exactly one cycle. It rises, and `busy` falls, at the 14th (short) or 128th (long) clock edge after the edge that accepted `start`.
- R7: A `start` pulse while `busy` is high is ignored: the frame keeps its timing, format, data and result.
- R8: Synchronous active-low reset clears `busy`, `done` and `word_out`. `word_out` holds its value from one `done` pulse until the next.
- R9: With CRC enabled, the payload bits of `word_out` equal the captured payload bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a frame (taken only when idle) |
| fmt_sel | input | 1 | 0: 20-bit short word, 1: 134-bit long packet |
| crc_en | input | 1 | 1: replace the check field with the computed CRC |
| raw_word | input | 134 | Word contents as held in the registers |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse: `word_out` updated |
| word_out | output | 134 | Assembled word |

## Verification
The bench builds the block with the default parameters: a 14-bit short payload, a 128-bit long payload and a 6-bit CRC. With these values the 7-bit bit counter runs through its full range, up to 127, on long frames. The same values put both the short and long merge boundaries into the generated bit map. Random and all-zero payloads in both formats are compared with a bitwise model of the shift register. Ignored starts are poked mid-frame with different inputs, and the exact cycle of the `done` pulse is checked for each format.

// File: rtl/crc6fb_pkg.sv
// Shared types for the CRC-6 frame builder.
package crc6fb_pkg;
    // Frame format selected at start.
    typedef enum logic {
        FMT_SHORT = 1'b0,
        FMT_LONG  = 1'b1
    } frame_fmt_e;
endpackage

// File: rtl/crc6fb_lfsr.sv
// Serial CRC shift register with a programmable polynomial and preset.
// Assumes init and step are never high together; init wins if they are.
// Output shifted is the state after absorbing din, so the final CRC can be
// used in the same cycle the last payload bit is applied.
module crc6fb_lfsr #(
    parameter int           W      = 6,
    parameter logic [W-1:0] POLY   = 'h03,
    parameter logic [W-1:0] PRESET = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] shifted
);
    logic [W-1:0] state;
    logic         fb;

    // Next value after one input bit: shift left, fold in polynomial on feedback.
    always_comb begin
        fb      = din ^ state[W-1];
        shifted = {state[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // State register: preset on init, advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n)     state <= PRESET;
        else if (init)  state <= PRESET;
        else if (step)  state <= shifted;
    end

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> state == PRESET); // R2
    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !step) |=> $stable(state)); // R2
endmodule

// File: rtl/crc6fb_seq.sv
// Frame sequencer: accepts start when idle, latches the format, and walks a
// bit index from 0 up to the last payload bit of the chosen format.
// Assumes SHORT_PAY and LONG_PAY both fit in a CNT_W-bit index.
module crc6fb_seq
    import crc6fb_pkg::*;
#(
    parameter int SHORT_PAY = 14,
    parameter int LONG_PAY  = 128,
    parameter int CNT_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fmt_in,
    output logic             accept,
    output logic             busy,
    output frame_fmt_e       fmt_q,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_PAY - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_PAY - 1);

    logic [CNT_W-1:0] lim;

    // Start is taken only when idle; last marks the final payload bit.
    always_comb begin
        lim    = (fmt_q == FMT_LONG) ? LONG_LAST : SHORT_LAST;
        accept = start && !busy;
        last   = busy && (cnt == lim);
    end

    // Busy flag, format latch and bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            fmt_q <= FMT_SHORT;
        end else if (accept) begin
            busy  <= 1'b1;
            cnt   <= '0;
            fmt_q <= frame_fmt_e'(fmt_in);
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy && (cnt == CNT_W'($past(cnt) + 1'b1))); // R7
    AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> $stable(fmt_q)); // R7
    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy); // R6
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cnt <= LONG_LAST); // R6
endmodule

// File: rtl/crc6fb_merge.sv
// Word assembly: places the CRC above the payload of the chosen format or
// passes the raw bits through. Bits above a short word are forced to zero.
// Assumes SHORT_PAY + CRC_W <= LONG_PAY.
module crc6fb_merge #(
    parameter int SHORT_PAY = 14,
    parameter int LONG_PAY  = 128,
    parameter int CRC_W     = 6
) (
    input  logic                      fmt_long,
    input  logic                      crc_en,
    input  logic [LONG_PAY+CRC_W-1:0] data,
    input  logic [CRC_W-1:0]          crc,
    output logic [LONG_PAY+CRC_W-1:0] word
);
    localparam int SHORT_LEN = SHORT_PAY + CRC_W;
    localparam int LONG_LEN  = LONG_PAY + CRC_W;

    // One mux per output bit, picked by the bit's region in each format.
    for (genvar i = 0; i < LONG_LEN; i++) begin : g_bit
        if (i < SHORT_PAY) begin : g_pay
            assign word[i] = data[i];
        end else if (i < SHORT_LEN) begin : g_short_crc
            assign word[i] = (fmt_long || !crc_en) ? data[i] : crc[i - SHORT_PAY];
        end else if (i < LONG_PAY) begin : g_mid
            assign word[i] = fmt_long ? data[i] : 1'b0;
        end else begin : g_long_crc
            assign word[i] = !fmt_long ? 1'b0 : (crc_en ? crc[i - LONG_PAY] : data[i]);
        end
    end
endmodule

// File: rtl/crc6_frame_builder.sv
// Top: captures a raw copy-protection word, runs a serial CRC-6 over its
// payload (one bit per clock, bit 0 first) and returns the assembled word
// with a one-cycle done pulse. Assumes start is synchronous to clk.
module crc6_frame_builder
    import crc6fb_pkg::*;
#(
    parameter int               SHORT_PAY = 14,
    parameter int               LONG_PAY  = 128,
    parameter int               CRC_W     = 6,
    parameter logic [CRC_W-1:0] POLY      = 'h03,
    parameter logic [CRC_W-1:0] PRESET    = '1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      fmt_sel,
    input  logic                      crc_en,
    input  logic [LONG_PAY+CRC_W-1:0] raw_word,
    output logic                      busy,
    output logic                      done,
    output logic [LONG_PAY+CRC_W-1:0] word_out
);
    localparam int SHORT_LEN = SHORT_PAY + CRC_W;
    localparam int LONG_LEN  = LONG_PAY + CRC_W;
    localparam int CNT_W     = $clog2(LONG_PAY);

    logic                accept;
    logic                last_w;
    frame_fmt_e          fmt_w;
    logic [CNT_W-1:0]    cnt;
    logic [LONG_LEN-1:0] data_q;
    logic                en_q;
    logic                cur_bit;
    logic [CRC_W-1:0]    crc_nxt;
    logic [LONG_LEN-1:0] merged;

    crc6fb_seq #(
        .SHORT_PAY (SHORT_PAY),
        .LONG_PAY  (LONG_PAY),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .fmt_in (fmt_sel),
        .accept (accept),
        .busy   (busy),
        .fmt_q  (fmt_w),
        .cnt    (cnt),
        .last   (last_w)
    );

    // Payload bit for this step.
    always_comb cur_bit = data_q[cnt];

    crc6fb_lfsr #(
        .W      (CRC_W),
        .POLY   (POLY),
        .PRESET (PRESET)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (accept),
        .step    (busy),
        .din     (cur_bit),
        .shifted (crc_nxt)
    );

    crc6fb_merge #(
        .SHORT_PAY (SHORT_PAY),
        .LONG_PAY  (LONG_PAY),
        .CRC_W     (CRC_W)
    ) u_merge (
        .fmt_long (fmt_w == FMT_LONG),
        .crc_en   (en_q),
        .data     (data_q),
        .crc      (crc_nxt),
        .word     (merged)
    );

    // Capture raw word and enable when a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            en_q   <= 1'b0;
        end else if (accept) begin
            data_q <= raw_word;
            en_q   <= crc_en;
        end
    end

    // Publish the assembled word and pulse done after the last payload bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            word_out <= '0;
        end else begin
            done <= last_w;
            if (last_w) word_out <= merged;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_w |=> done && !busy); // R6
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !last_w |=> $stable(word_out)); // R8
    AST_PASSTHRU_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !en_q && fmt_w == FMT_LONG) |-> word_out == data_q); // R5
    AST_PASSTHRU_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !en_q && fmt_w == FMT_SHORT)
            |-> word_out[SHORT_LEN-1:0] == data_q[SHORT_LEN-1:0]); // R5
    AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fmt_w == FMT_SHORT) |-> word_out[LONG_LEN-1:SHORT_LEN] == '0); // R3
    AST_PAYLOAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && en_q && fmt_w == FMT_LONG)
            |-> word_out[LONG_PAY-1:0] == data_q[LONG_PAY-1:0]); // R9
endmodule

// File: tb/sim_crc6_frame_builder.sv
`timescale 1ns/1ps
module sim_crc6_frame_builder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         fmt_sel = 1'b0;
    logic         crc_en = 1'b0;
    logic [133:0] raw_word = '0;
    logic         busy;
    logic         done;
    logic [133:0] word_out;
    int           n_cmp = 0;
    int           n_bad = 0;

    always #4 clk = ~clk;

    crc6_frame_builder u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_sel(fmt_sel),
        .crc_en(crc_en), .raw_word(raw_word), .busy(busy), .done(done),
        .word_out(word_out)
    );

    // Bitwise model of the CRC register (R2).
    function automatic logic [5:0] crc_ref(input logic [133:0] d, input int n);
        logic [5:0] r = 6'h3F;
        for (int i = 0; i < n; i++) begin
            logic f = d[i] ^ r[5];
            r = {r[4:0], 1'b0} ^ {4'b0000, f, f};
        end
        return r;
    endfunction

    // Expected assembled word (R3, R4, R5, R9).
    function automatic logic [133:0] exp_word(input logic lng, input logic en,
                                              input logic [133:0] d);
        logic [133:0] w = '0;
        if (!lng) begin
            w[19:0] = d[19:0];
            if (en) w[19:14] = crc_ref(d, 14);
        end else begin
            w = d;
            if (en) w[133:128] = crc_ref(d, 128);
        end
        return w;
    endfunction

    function automatic logic [133:0] rnd134();
        logic [133:0] v = '0;
        for (int j = 0; j < 5; j++) v = {v[101:0], $urandom()};
        return v;
    endfunction

    task automatic chk(input string tag, input logic [133:0] act, input logic [133:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One frame; poke=1 adds an ignored start with different inputs (R7).
    task automatic run_frame(input logic lng, input logic en,
                             input logic [133:0] d, input logic poke);
        int n = lng ? 128 : 14;
        logic [133:0] e = exp_word(lng, en, d);
        @(negedge clk);
        fmt_sel = lng; crc_en = en; raw_word = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0; fmt_sel = ~lng; crc_en = ~en; raw_word = ~d;
        chk("R1 busy after start", {133'b0, busy}, 134'd1);
        for (int k = 1; k < n; k++) begin
            @(negedge clk);
            start = (poke && k == 2);
            raw_word = rnd134();
        end
        start = 1'b0;
        chk("R6 no early done", {132'b0, busy, done}, 134'd2);
        @(negedge clk);
        chk("R6 done and idle", {132'b0, busy, done}, 134'd1);
        chk(lng ? (en ? "R4 long CRC word" : "R5 long passthrough")
                : (en ? "R3 short CRC word" : "R5 short passthrough"), word_out, e);
        if (poke) chk("R7 ignored start", word_out, e);
        if (en) chk("R9 payload kept", lng ? {6'b0, word_out[127:0]} : {120'b0, word_out[13:0]},
                    lng ? {6'b0, d[127:0]} : {120'b0, d[13:0]});
        @(negedge clk);
        chk("R6 done single cycle", {133'b0, done}, 134'd0);
        chk("R8 word held", word_out, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset state", {word_out[131:0], busy, done}, '0);
        run_frame(1'b0, 1'b1, '0, 1'b0);
        run_frame(1'b1, 1'b1, '0, 1'b0);
        run_frame(1'b0, 1'b1, '1, 1'b0);
        run_frame(1'b1, 1'b1, '1, 1'b0);
        run_frame(1'b0, 1'b0, '1, 1'b0);
        run_frame(1'b1, 1'b0, rnd134(), 1'b0);
        run_frame(1'b0, 1'b1, rnd134(), 1'b1);
        run_frame(1'b1, 1'b1, rnd134(), 1'b1);
        for (int t = 0; t < 24; t++) begin
            logic [31:0] s = $urandom();
            run_frame(s[0], s[1] | s[2], rnd134(), s[3]);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule